// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block executes a single loop-control primitive for a small accumulator-style core. One instruction postbyte selects a register, picks whether that register is decremented, incremented or merely tested, and picks whether the branch fires on a zero or a non-zero result. A second byte holds the low eight bits of a branch displacement, and the postbyte supplies the ninth, sign bit.

The unit reads the chosen register through a combinational read port that it indexes itself. It computes the updated count and always writes it back to the same register. It also produces the branch decision and the target address, which is the current PC plus the 9-bit signed displacement. All results are registered and appear one cycle after the request. An encoding with no defined operation suppresses both the write-back and the branch, and raises a one-cycle illegal flag instead. Instruction fetch and the register file sit outside this block.

Top module: `loop_branch_unit`

## Requirements
- R1: Postbyte bits 7:6 select the adjustment applied to the register value: 2'b00 subtracts one, 2'b10 adds one, and 2'b01 adds zero (test only).
- R2: Postbyte bits 7:6 equal to 2'b11 is illegal. One cycle after the request, illegal_o is high for exactly one cycle, and wr_en_o and taken_o stay low.
- R3: The branch displacement is 9 bits, formed as {postbyte bit 4, offset byte}, and is sign-extended to 16 bits. target_o equals pc_i plus this displacement, modulo 2^16.
- R4: Postbyte bits 2:0 are the register index. rd_idx_o carries this index combinationally in the same cycle as the request, and wr_idx_o carries it with the result. The codes are 0=A, 1=B, 2=flags, 3=scratch, 4=D, 5=X, 6=Y, 7=SP.
- R5: Postbyte bit 5 set means the branch is taken when the updated value is non-zero. Bit 5 clear means the branch is taken when the updated value is zero.
- R6: For every legal request, wr_en_o pulses with the updated value, whether or not the branch is taken.
- R7: For register codes 0, 1 and 2, only the low 8 bits of rd_data_i are adjusted and tested for zero, with wrap-around at 8 bits. Bits 15:8 of wr_data_o are zero. Codes 3 to 7 use all 16 bits.
- R8: Results are registered and valid exactly one cycle after valid_i. A cycle without valid_i gives wr_en_o, taken_o and illegal_o low in the next cycle.
- R9: While rst_ni is low, every output register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe for one instruction |
| pbyte_i | input | 8 | Postbyte: operation, condition, displacement sign, register index |
| disp_i | input | 8 | Low 8 bits of the branch displacement |
| pc_i | input | 16 | PC that the displacement is added to |
| rd_idx_o | output | 3 | Register read index (combinational) |
| rd_data_i | input | 16 | Register value returned for rd_idx_o |
| wr_en_o | output | 1 | Write-back strobe |
| wr_idx_o | output | 3 | Write-back register index |
| wr_data_o | output | 16 | Updated register value |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Branch target address |
| illegal_o | output | 1 | Illegal operation encoding seen |

## Verification
Random postbytes cover all four operation codes, both conditions, both displacement signs and all eight register codes, with random register values and PCs. This separates the 8-bit and 16-bit paths, because the upper register bits are random. Directed cases aim at the values that make the zero test matter: a count of one being decremented, an all-ones value being incremented at both widths, and a zero being tested under each condition. These cases tell the taken and not-taken decisions apart from the write-back, which happens in both. Negative displacements at PC zero and a positive one near the top of memory exercise wrap-around of the target. Idle cycles after each request confirm that the output strobes last a single cycle.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    OP_DEC = 2'b00,
    OP_TST = 2'b01,
    OP_INC = 2'b10,
    OP_BAD = 2'b11
  } lcb_op_e;

  typedef struct packed {
    lcb_op_e          op;
    logic             on_nz;
    logic             disp_neg;
    logic [IDX_W-1:0] idx;
  } lcb_dec_t;
endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
  import lcb_pkg::*;
(
  input  logic [7:0] pbyte_i,
  output lcb_dec_t   dec_o
);
  logic unused_bit;
  assign unused_bit     = pbyte_i[3];
  assign dec_o.op       = lcb_op_e'(pbyte_i[7:6]);
  assign dec_o.on_nz    = pbyte_i[5];
  assign dec_o.disp_neg = pbyte_i[4];
  assign dec_o.idx      = pbyte_i[IDX_W-1:0];
endmodule

// File: rtl/lcb_count.sv
module lcb_count
  import lcb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic              narrow_i,
  input  lcb_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0]   delta;
  logic [DATA_W-1:0]   res_wide;
  logic [NARROW_W-1:0] res_narrow;

  always_comb begin
    unique case (op_i)
      OP_DEC:  delta = '1;
      OP_INC:  delta = DATA_W'(1);
      default: delta = '0;
    endcase
  end

  assign res_wide   = src_i + delta;
  assign res_narrow = src_i[NARROW_W-1:0] + delta[NARROW_W-1:0];
  assign res_o      = narrow_i ? {{PAD_W{1'b0}}, res_narrow} : res_wide;
  assign zero_o     = (res_o == '0);
endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              neg_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = ADDR_W - OFF_W;
  // displacement sign lives outside the offset byte
  assign target_o = pc_i + {{EXT_W{neg_i}}, off_i};
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lcb_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int NARROW_W    = 8,
  parameter int NARROW_REGS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        pbyte_i,
  input  logic [7:0]        disp_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              illegal_o
);
  lcb_dec_t          dec;
  logic              narrow;
  logic              bad;
  logic [DATA_W-1:0] res;
  logic              zero;
  logic              cond;
  logic [ADDR_W-1:0] target;

  lcb_decode u_dec (.pbyte_i(pbyte_i), .dec_o(dec));

  assign rd_idx_o = dec.idx;
  assign narrow   = (int'(dec.idx) < NARROW_REGS);
  assign bad      = (dec.op == OP_BAD);

  lcb_count #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .src_i(rd_data_i), .narrow_i(narrow), .op_i(dec.op),
    .res_o(res), .zero_o(zero)
  );

  lcb_target #(.ADDR_W(ADDR_W), .OFF_W(8)) u_tgt (
    .pc_i(pc_i), .off_i(disp_i), .neg_i(dec.disp_neg), .target_o(target)
  );

  assign cond = dec.on_nz ? !zero : zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      taken_o   <= 1'b0;
      target_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      wr_en_o   <= valid_i && !bad;
      taken_o   <= valid_i && !bad && cond;
      illegal_o <= valid_i && bad;
      if (valid_i) begin
        wr_idx_o  <= dec.idx;
        wr_data_o <= res;
        target_o  <= target;
      end
    end
  end

  // R2
  illegal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && !taken_o));

  // R2
  illegal_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($past(valid_i) && $past(pbyte_i[7:6]) == 2'b11));

  // R6
  writeback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pbyte_i[7:6] != 2'b11) |=> wr_en_o);

  // R8
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wr_en_o && !taken_o && !illegal_o));

  // R5
  taken_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> wr_en_o);

  // R7
  narrow_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && int'(wr_idx_o) < NARROW_REGS) |-> wr_data_o[DATA_W-1:NARROW_W] == '0);

  // R4
  wr_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> wr_idx_o == $past(pbyte_i[2:0]));
endmodule

// File: tb/loop_branch_unit_test.sv
module loop_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  pbyte = '0;
  logic [7:0]  disp = '0;
  logic [15:0] pc = '0;
  logic [2:0]  rd_idx;
  logic [15:0] rd_data = '0;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [15:0] wr_data;
  logic        taken;
  logic [15:0] target;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  loop_branch_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pbyte_i(pbyte),
    .disp_i(disp), .pc_i(pc), .rd_idx_o(rd_idx), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .taken_o(taken), .target_o(target), .illegal_o(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_val(input logic [7:0] pb, input logic [15:0] v);
    logic [15:0] d;
    logic [7:0]  lo;
    d = (pb[7:6] == 2'b00) ? 16'hFFFF : (pb[7:6] == 2'b10) ? 16'h0001 : 16'h0000;
    if (pb[2:0] < 3) begin
      lo = v[7:0] + d[7:0];
      return {8'h00, lo};
    end
    return v + d;
  endfunction

  function automatic logic exp_taken(input logic [7:0] pb, input logic [15:0] v);
    logic z;
    z = (exp_val(pb, v) == 16'h0);
    return pb[5] ? !z : z;
  endfunction

  function automatic logic [15:0] exp_tgt(input logic [7:0] pb, input logic [7:0] o,
                                          input logic [15:0] p);
    return p + {{8{pb[4]}}, o};
  endfunction

  task automatic run(input logic [7:0] pb, input logic [7:0] o, input logic [15:0] p,
                     input logic [15:0] v, input bit idle);
    logic bad;
    bad = (pb[7:6] == 2'b11);
    @(negedge clk);
    valid = 1'b1; pbyte = pb; disp = o; pc = p; rd_data = v;
    #1;
    chk(rd_idx == pb[2:0], "R4 rd_idx", 16'(rd_idx), 16'(pb[2:0]));
    @(negedge clk);
    valid = 1'b0;
    pbyte = 8'($urandom); disp = 8'($urandom); pc = 16'($urandom); rd_data = 16'($urandom);
    chk(illegal == bad, "R2 illegal", 16'(illegal), 16'(bad));
    if (bad) begin
      chk(!wr_en && !taken, "R2 suppress", {wr_en, taken}, 16'h0);
    end else begin
      chk(wr_en, "R6 wr_en", 16'(wr_en), 16'h1);
      chk(wr_idx == pb[2:0], "R4 wr_idx", 16'(wr_idx), 16'(pb[2:0]));
      chk(wr_data == exp_val(pb, v), (pb[2:0] < 3) ? "R7 narrow data" : "R1 data",
          wr_data, exp_val(pb, v));
      chk(taken == exp_taken(pb, v), "R5 taken", 16'(taken), 16'(exp_taken(pb, v)));
      chk(target == exp_tgt(pb, o, p), "R3 target", target, exp_tgt(pb, o, p));
    end
    if (idle) begin
      @(negedge clk);
      chk(!wr_en && !taken && !illegal, "R8 one-cycle strobe",
          {wr_en, taken, illegal}, 16'h0);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    chk(!wr_en && !taken && !illegal && wr_data == 0 && target == 0 && wr_idx == 0,
        "R9 reset", {wr_en, taken, illegal}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 decrement 16-bit X from 1 to 0, branch on zero
    run(8'b00_0_0_0_101, 8'h10, 16'h1000, 16'h0001, 1'b1);
    // R5 same value, branch on non-zero: not taken, still written (R6)
    run(8'b00_1_0_0_101, 8'h10, 16'h1000, 16'h0001, 1'b1);
    // R7 decrement narrow A from 0 with junk upper bits: wraps to FF
    run(8'b00_1_0_0_000, 8'h04, 16'h2000, 16'hAB00, 1'b1);
    // R7 increment narrow B from FF: wraps to 0, taken on zero
    run(8'b10_0_0_0_001, 8'h04, 16'h2000, 16'h12FF, 1'b1);
    // R1 increment 16-bit SP from FFFF: wraps to 0
    run(8'b10_0_0_0_111, 8'h7F, 16'hFFF0, 16'hFFFF, 1'b1);
    // R1 test zero scratch register, both conditions
    run(8'b01_0_0_0_011, 8'h00, 16'h0100, 16'h0000, 1'b1);
    run(8'b01_1_0_0_011, 8'h00, 16'h0100, 16'h0000, 1'b1);
    // R3 negative displacement at PC zero wraps
    run(8'b00_1_1_0_110, 8'h80, 16'h0000, 16'h0005, 1'b1);
    run(8'b01_1_1_0_100, 8'hFF, 16'h0000, 16'h8000, 1'b1);
    // R2 illegal encoding
    run(8'b11_1_0_0_010, 8'h22, 16'h3000, 16'h0001, 1'b1);
    // random traffic, back to back and with gaps
    for (int i = 0; i < 400; i++) begin
      run(8'($urandom), 8'($urandom), 16'($urandom),
          ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 2)) : 16'($urandom),
          ($urandom_range(0, 1) == 1));
    end
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule